// File: doc/BRIEF.md
# Prescaled 16-bit Timer with Reload and Compare

This block is a 16-bit up-counter. A programmable prescaler derives its count tick from the system clock. A run-enable input starts and stops it. A mode input selects one of two behaviours.

In reload mode, a preset value is copied into the counter on a selected trigger. The trigger is either counter wrap-around or a strobe on one of three capture channels. The capture strobes come from a neighbouring capture unit. In compare mode, the counter is matched against the same preset value, and can optionally restart from zero after a match.

A sticky event flag reports wrap-around in reload mode and a match in compare mode. Software clears it with a strobe. A one-cycle "cleared" output tells the capture unit when the count was forced to zero. A capture-clear option zeroes the counter on any capture strobe, which turns the timer into a direct period meter.

All pins are plain control and status signals; the block has no streaming data path, so no valid/ready handshake is involved.

Top module: `pscl_timer16`

## Requirements
- R1: After reset `count` is 0000h, `flag` is 0 and `cleared` is 0.
- R2: While `run_en` is 0 the counter holds its value, and capture strobes have no effect on it.
- R3: `div_sel` sets the tick period in clock cycles: code 0 gives 1, code 1 gives 4, code 2 gives 16, code 3 gives 32, code 4 gives 64, code 5 gives 128, code 6 gives 256 and code 7 gives 512. The first tick comes N cycles after `run_en` rises. Dropping `run_en` for any cycle restarts the prescaler.
- R4: On a tick at FFFFh with `mode_cmp`=0, the counter loads `preset` if `reload_en`=1 and `trig_sel`=0; otherwise it wraps to 0000h.
- R5: With `mode_cmp`=0 and `reload_en`=1, a `trig_sel` of 1, 2 or 3 selects capture bit 0, 1 or 2. A strobe on the selected bit loads `preset` at the next clock edge, whether or not a tick is due.
- R6: Strobes on capture bits not named by `trig_sel` never cause a reload; the counter advances normally.
- R7: In reload mode a wrap-around from FFFFh sets `flag`.
- R8: `flag` stays 1 until `flag_clr` is pulsed. When `flag_clr` and a new flag event fall in the same cycle, `flag` stays 1.
- R9: While running with `cap_clr_en`=1, a strobe on any capture bit forces the counter to 0000h. This takes priority over any reload. `cleared` is then 1 for exactly one cycle.
- R10: With `mode_cmp`=1, `flag` is set on the same edge at which a tick brings the counter to `preset`.
- R11: With `mode_cmp`=1 and `cmp_clr_en`=1, the tick after the counter equals `preset` takes it to 0000h instead of incrementing, and `cleared` is 1 for one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| run_en | input | 1 | Counter runs while 1 |
| div_sel | input | 3 | Prescaler divisor code |
| mode_cmp | input | 1 | 0 = reload mode, 1 = compare mode |
| reload_en | input | 1 | Enables loading of `preset` in reload mode |
| trig_sel | input | 2 | Reload trigger: 0 wrap, 1..3 capture bit 0..2 |
| cap_clr_en | input | 1 | Capture strobe zeroes the counter |
| cmp_clr_en | input | 1 | Compare match restarts the counter from zero |
| preset | input | 16 | Reload / compare value |
| cap_evt | input | 3 | One-cycle capture strobes, one per channel |
| flag_clr | input | 1 | Clears the sticky flag |
| count | output | 16 | Current counter value |
| flag | output | 1 | Sticky wrap / match flag |
| cleared | output | 1 | One-cycle pulse after a forced clear |

## Verification
A corrupted prescaler phase shows up as a counter step landing one or more cycles away from the tick position computed from `div_sel`. The mismatch is visible on `count` within one division period. A wrong priority between capture-clear, capture reload and wrap-around appears on `count` at the very next edge after the strobe or wrap: the counter reads zero, `preset` or an increment where a different one is due. A flag that is lost or spuriously held is seen on `flag` one cycle after the event or the clear strobe. Compare-mode errors appear either as `flag` rising on the wrong count or as `count` failing to return to zero on the tick after the match.

// File: rtl/tmr16_pkg.sv
package tmr16_pkg;
  // log2 of the prescaler divisor for each select code
  function automatic int unsigned div_shift(input int unsigned code);
    if (code == 0)      return 0;
    else if (code == 1) return 2;
    else                return code + 2;
  endfunction
endpackage

// File: rtl/tmr16_prescale.sv
module tmr16_prescale #(
  parameter int SEL_W = 3,
  parameter int PS_W  = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] div_sel,
  output logic             tick
);
  logic [PS_W-1:0] pcnt;
  logic [PS_W-1:0] lim;

  always_comb begin
    lim  = PS_W'((1 << tmr16_pkg::div_shift(32'(div_sel))) - 1);
    tick = run_en && (pcnt >= lim);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              pcnt <= '0;
    else if (!run_en || tick) pcnt <= '0;
    else                      pcnt <= pcnt + 1'b1;
  end
endmodule

// File: rtl/tmr16_core.sv
module tmr16_core #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3,
  parameter int TS_W  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic             tick,
  input  logic             mode_cmp,
  input  logic             reload_en,
  input  logic [TS_W-1:0]  trig_sel,
  input  logic             cap_clr_en,
  input  logic             cmp_clr_en,
  input  logic [CNT_W-1:0] preset,
  input  logic [NCH-1:0]   cap_evt,
  output logic [CNT_W-1:0] count,
  output logic             cleared,
  output logic             ovf_evt,
  output logic             match_evt
);
  logic [CNT_W-1:0] nxt, inc;
  logic             sel_hit, any_hit, clr_now, at_top;

  always_comb begin
    sel_hit = 1'b0;
    for (int i = 0; i < NCH; i++)
      if (trig_sel == TS_W'(i + 1) && cap_evt[i]) sel_hit = 1'b1;
    any_hit   = |cap_evt;
    inc       = count + 1'b1;
    at_top    = &count;
    nxt       = count;
    clr_now   = 1'b0;
    ovf_evt   = 1'b0;
    match_evt = 1'b0;
    if (run_en) begin
      if (cap_clr_en && any_hit) begin
        nxt     = '0;
        clr_now = 1'b1;
      end else if (!mode_cmp && reload_en && sel_hit) begin
        nxt = preset;
      end else if (tick) begin
        if (mode_cmp && cmp_clr_en && count == preset) begin
          nxt     = '0;
          clr_now = 1'b1;
        end else if (!mode_cmp && at_top) begin
          ovf_evt = 1'b1;
          nxt     = (reload_en && trig_sel == '0) ? preset : '0;
        end else begin
          nxt       = inc;
          match_evt = mode_cmp && (inc == preset);
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      count   <= '0;
      cleared <= 1'b0;
    end else begin
      count   <= nxt;
      cleared <= clr_now;
    end
  end
endmodule

// File: rtl/tmr16_flag.sv
module tmr16_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_evt | (flag & ~clr_req);
  end
endmodule

// File: rtl/pscl_timer16.sv
module pscl_timer16 #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3,
  parameter int SEL_W = 3,
  localparam int TS_W = $clog2(NCH + 1),
  localparam int PS_W = (1 << SEL_W) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  logic [SEL_W-1:0] div_sel,
  input  logic             mode_cmp,
  input  logic             reload_en,
  input  logic [TS_W-1:0]  trig_sel,
  input  logic             cap_clr_en,
  input  logic             cmp_clr_en,
  input  logic [CNT_W-1:0] preset,
  input  logic [NCH-1:0]   cap_evt,
  input  logic             flag_clr,
  output logic [CNT_W-1:0] count,
  output logic             flag,
  output logic             cleared
);
  logic tick, ovf_evt, match_evt;

  tmr16_prescale #(.SEL_W(SEL_W), .PS_W(PS_W)) u_ps (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel), .tick(tick)
  );

  tmr16_core #(.CNT_W(CNT_W), .NCH(NCH), .TS_W(TS_W)) u_core (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .tick(tick),
    .mode_cmp(mode_cmp), .reload_en(reload_en), .trig_sel(trig_sel),
    .cap_clr_en(cap_clr_en), .cmp_clr_en(cmp_clr_en), .preset(preset),
    .cap_evt(cap_evt), .count(count), .cleared(cleared),
    .ovf_evt(ovf_evt), .match_evt(match_evt)
  );

  tmr16_flag u_flag (
    .clk(clk), .rst_n(rst_n), .set_evt(ovf_evt | match_evt),
    .clr_req(flag_clr), .flag(flag)
  );
endmodule

// File: rtl/tmr16_chk.sv
module tmr16_chk #(
  parameter int CNT_W = 16,
  parameter int NCH   = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run_en,
  input logic             mode_cmp,
  input logic             cap_clr_en,
  input logic [CNT_W-1:0] preset,
  input logic [NCH-1:0]   cap_evt,
  input logic             flag_clr,
  input logic [CNT_W-1:0] count,
  input logic             flag,
  input logic             cleared
);
  AST_HOLD_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> count == $past(count)); // R2

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && !(|cap_evt)) |=> (count == $past(count) || count == CNT_W'($past(count) + 1'b1)
                                 || count == $past(preset) || count == '0)); // R4

  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag); // R8

  AST_CAP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (run_en && cap_clr_en && (|cap_evt)) |=> (count == '0 && cleared)); // R9

  AST_CLEARED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    cleared |-> count == '0); // R11

  AST_CMP_HIT: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(mode_cmp) && !$past(flag) && flag) |-> count == $past(preset)); // R10
endmodule

bind pscl_timer16 tmr16_chk #(.CNT_W(CNT_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .mode_cmp(mode_cmp),
  .cap_clr_en(cap_clr_en), .preset(preset), .cap_evt(cap_evt),
  .flag_clr(flag_clr), .count(count), .flag(flag), .cleared(cleared)
);

// File: tb/pscl_timer16_test.sv
module pscl_timer16_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        run_en;
  logic [2:0]  div_sel;
  logic        mode_cmp, reload_en, cap_clr_en, cmp_clr_en, flag_clr;
  logic [1:0]  trig_sel;
  logic [15:0] preset;
  logic [2:0]  cap_evt;
  logic [15:0] count;
  logic        flag, cleared;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  pscl_timer16 uut (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .div_sel(div_sel),
    .mode_cmp(mode_cmp), .reload_en(reload_en), .trig_sel(trig_sel),
    .cap_clr_en(cap_clr_en), .cmp_clr_en(cmp_clr_en), .preset(preset),
    .cap_evt(cap_evt), .flag_clr(flag_clr), .count(count), .flag(flag),
    .cleared(cleared)
  );

  // {div code (4b), cycles run (12b), expected count (16b)}
  localparam logic [31:0] VEC [8] = '{
    {4'd0, 12'd5,    16'd5}, {4'd1, 12'd9,    16'd2},
    {4'd2, 12'd33,   16'd2}, {4'd3, 12'd64,   16'd2},
    {4'd4, 12'd127,  16'd1}, {4'd5, 12'd256,  16'd2},
    {4'd6, 12'd600,  16'd2}, {4'd7, 12'd1024, 16'd2}
  };

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0; run_en = 1'b0; div_sel = '0; mode_cmp = 1'b0; reload_en = 1'b0;
    trig_sel = '0; cap_clr_en = 1'b0; cmp_clr_en = 1'b0; flag_clr = 1'b0;
    preset = '0; cap_evt = '0;
    step(2);
    rst_n = 1'b1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  endtask

  initial begin
    do_reset();
    chk("R1 count", count, 16'h0000);
    chk("R1 flag", {15'd0, flag}, 16'd0);
    chk("R1 cleared", {15'd0, cleared}, 16'd0);

    // R3 divisor table
    for (int i = 0; i < 8; i++) begin
      do_reset();
      div_sel = VEC[i][30:28];
      run_en  = 1'b1;
      step(int'(VEC[i][27:16]));
      chk($sformatf("R3 div code %0d", i), count, VEC[i][15:0]);
    end

    // R3 prescaler restart on disable
    do_reset();
    div_sel = 3'd1; run_en = 1'b1; step(3);
    run_en = 1'b0; step(1);
    run_en = 1'b1; step(3);
    chk("R3 restart", count, 16'd0);
    step(1);
    chk("R3 restart tick", count, 16'd1);

    // R2 stopped counter ignores strobes
    run_en = 1'b0; cap_clr_en = 1'b1; cap_evt = 3'b111; step(1);
    cap_evt = '0; step(3);
    chk("R2 hold", count, 16'd1);
    chk("R2 no clear", {15'd0, cleared}, 16'd0);
    cap_clr_en = 1'b0;

    // R5 / R6 capture-triggered reload
    do_reset();
    run_en = 1'b1; reload_en = 1'b1; trig_sel = 2'd2; preset = 16'h0050;
    step(3);
    chk("R6 pre", count, 16'd3);
    cap_evt = 3'b001; step(1);
    chk("R6 unselected", count, 16'd4);
    cap_evt = 3'b010; step(1);
    chk("R5 reload ch1", count, 16'h0050);
    preset = 16'hFFFE; trig_sel = 2'd3; cap_evt = 3'b100; step(1);
    chk("R5 reload ch2", count, 16'hFFFE);

    // R4 / R7 wrap with reload
    cap_evt = '0; trig_sel = 2'd0; preset = 16'h1234; step(1);
    chk("R4 top", count, 16'hFFFF);
    chk("R7 no flag yet", {15'd0, flag}, 16'd0);
    step(1);
    chk("R4 wrap reload", count, 16'h1234);
    chk("R7 flag", {15'd0, flag}, 16'd1);
    step(3);
    chk("R8 sticky", {15'd0, flag}, 16'd1);
    flag_clr = 1'b1; step(1); flag_clr = 1'b0;
    chk("R8 cleared", {15'd0, flag}, 16'd0);

    // R8 set wins over clear; R4 plain wrap
    preset = 16'hFFFF; trig_sel = 2'd1; cap_evt = 3'b001; step(1);
    chk("R5 reload top", count, 16'hFFFF);
    cap_evt = '0; trig_sel = 2'd0; reload_en = 1'b0; flag_clr = 1'b1; step(1);
    flag_clr = 1'b0;
    chk("R4 wrap zero", count, 16'h0000);
    chk("R8 set wins", {15'd0, flag}, 16'd1);

    // R9 capture clear beats reload
    reload_en = 1'b1; trig_sel = 2'd1; preset = 16'h4444; cap_clr_en = 1'b1;
    step(2);
    cap_evt = 3'b001; step(1);
    cap_evt = '0;
    chk("R9 clear", count, 16'h0000);
    chk("R9 pulse", {15'd0, cleared}, 16'd1);
    step(1);
    chk("R9 resume", count, 16'd1);
    chk("R9 pulse end", {15'd0, cleared}, 16'd0);
    cap_evt = 3'b100; step(1);
    cap_evt = '0;
    chk("R9 any channel", count, 16'h0000);
    cap_clr_en = 1'b0;

    // R10 compare without clear
    do_reset();
    mode_cmp = 1'b1; preset = 16'd5; run_en = 1'b1;
    step(4);
    chk("R10 before", count, 16'd4);
    chk("R10 no flag", {15'd0, flag}, 16'd0);
    step(1);
    chk("R10 match cnt", count, 16'd5);
    chk("R10 match flag", {15'd0, flag}, 16'd1);
    step(1);
    chk("R10 keeps counting", count, 16'd6);

    // R11 compare clear
    do_reset();
    mode_cmp = 1'b1; cmp_clr_en = 1'b1; preset = 16'd3; run_en = 1'b1;
    step(3);
    chk("R11 at preset", count, 16'd3);
    step(1);
    chk("R11 cleared cnt", count, 16'd0);
    chk("R11 pulse", {15'd0, cleared}, 16'd1);
    step(1);
    chk("R11 restart", count, 16'd1);

    // R1 reset after activity
    do_reset();
    chk("R1 re-reset", count, 16'd0);
    chk("R1 re-reset flag", {15'd0, flag}, 16'd0);

    finish_run();
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end
endmodule